// File: doc/BRIEF.md
# Three-Rail Enable Sequencer

This controller brings up three supply rails one after another from a single enable request and takes them down again in a selectable order. Each rail has an active-high enable output. When the request rises, rail 1 is released after a first delay, rail 2 a second delay later and rail 3 a third delay after that. When the request falls, the rails are dropped one by one in the order chosen by a 3-bit order select, with three down-timers of their own. All delays share one value picked by a 3-bit delay option. Time is counted in pulses of a periodic timebase input, one pulse per 100 us.

A short request glitch that ends before any rail has moved is filtered: the sequence aborts and the outputs return to their resting level. A request change that arrives once a rail has already moved does not reverse the sequence at once. The timer in progress restarts, the sequence runs to its end, the block waits a fixed settle time, and only then samples the request again and runs the opposite sequence if it is still called for. A busy output shows whenever a timer or the settle wait is in progress.

States: `ST_IDLE` (all low, resting), `ST_UP1`/`ST_UP2`/`ST_UP3` (waiting to release rail 1, 2, 3), `ST_ON` (all high, resting), `ST_DN1`/`ST_DN2`/`ST_DN3` (waiting to drop the first, second, third rail of the chosen order), `ST_HOLD_HI` (settle wait after an interrupted power-up, all high) and `ST_HOLD_LO` (settle wait after an interrupted power-down, all low). Transitions: IDLE→UP1 on request high; UP1→IDLE on request low (abort); UP1→UP2→UP3 on timer expiry; UP3→ON on expiry with request high, UP3→HOLD_HI with request low; ON→DN1 on request low; DN1→ON on request high (abort); DN1→DN2→DN3 on expiry; DN3→IDLE on expiry with request low, DN3→HOLD_LO with request high; HOLD_HI→ON or DN1 and HOLD_LO→UP1 or IDLE on expiry, chosen by the request level at that moment.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset `rail_en` is 3'b000 and `busy` is 0, and both stay so while `en` is low.
- R2: With `en` held high from the resting low state, `rail_en[0]` rises first, then `rail_en[1]`, then `rail_en[2]`; the gaps are D+4, D and D ticks, where D is the option delay in ticks; with a tick on every clock, `rail_en[0]` is seen high 105 cycles after `en` is driven high for option 1.
- R3: On a power-down from the all-high state the rails drop in the order set by `pd_order_sel` (rails numbered 1 to 3 for `rail_en[0..2]`): 1 → 3,2,1; 2 → 3,1,2; 3 → 2,3,1; 4 → 2,1,3; 5 → 1,3,2; 6 → 1,2,3; 0 and 7 act as 1. The gaps are D+4, D and D ticks.
- R4: `dly_opt_sel` values 1 to 6 give D = 10, 30, 60, 120, 2 and 16 ms (times 10 ticks); 0 and 7 act as 1. The first timer of each sequence adds 4 ticks.
- R5: If `en` falls while the first power-up timer is running, the block returns to the all-low resting state in the next cycle with `busy` low and no rail ever raised.
- R6: If `en` rises while the first power-down timer is running, the block returns to the all-high resting state in the next cycle with `busy` low and no rail ever dropped.
- R7: If `en` falls after rail 1 is up but before rail 3 is up, the running timer restarts from zero, power-up completes, the block holds all rails high for 1200 ticks with `busy` high, then starts power-down if `en` is still low.
- R8: If `en` rises after the first rail has dropped but before the last one, the running timer restarts from zero, power-down completes, the block holds all rails low for 1200 ticks with `busy` high, then starts power-up if `en` is still high.
- R9: If at the end of a settle hold `en` no longer calls for the opposite sequence, the block enters the matching resting state and stays there.
- R10: `busy` is low only in the two resting states (all low or all high) and high in every timing or settle state.
- R11: The order and delay selects are captured when a power-up or power-down starts; later changes have no effect on that sequence.
- R12: Timers advance only on cycles with `tick` high; without ticks no rail changes, and at most one rail changes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse, one cycle wide, every 100 us |
| en | input | 1 | Sequencing request, high to power up |
| pd_order_sel | input | 3 | Power-down order select |
| dly_opt_sel | input | 3 | Common delay option select |
| rail_en | output | 3 | Active-high rail enables, bit 0 is rail 1 |
| busy | output | 1 | High while a timer or settle wait runs |

## Verification
The assertions assume `en` and both selects are synchronous to `clk` and change only between edges, and that `tick` is a single-cycle pulse; they make no claim about timing in ticks, which the reference model covers. The bench drives every input on the falling edge, keeps `tick` periodic (every cycle, every third cycle, or off for a window), and toggles `en` only at chosen points inside the first timers, the later timers and the settle holds so that each glitch, interruption and re-sampling path is reached.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    localparam int N_RAILS = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UP1,
        ST_UP2,
        ST_UP3,
        ST_ON,
        ST_DN1,
        ST_DN2,
        ST_DN3,
        ST_HOLD_HI,
        ST_HOLD_LO
    } seq_state_e;

    // Out-of-range select codes fall back to code 1.
    function automatic logic [2:0] norm_sel(input logic [2:0] s);
        return (s == 3'd0 || s == 3'd7) ? 3'd1 : s;
    endfunction

    // Common delay in milliseconds for a delay option code.
    function automatic logic [7:0] opt_ms(input logic [2:0] s);
        logic [7:0] ms;
        unique case (norm_sel(s))
            3'd2:    ms = 8'd30;
            3'd3:    ms = 8'd60;
            3'd4:    ms = 8'd120;
            3'd5:    ms = 8'd2;
            3'd6:    ms = 8'd16;
            default: ms = 8'd10;
        endcase
        return ms;
    endfunction

    // Drop slot (0 = first) of each rail, packed {rail2, rail1, rail0}.
    function automatic logic [5:0] drop_slots(input logic [2:0] s);
        logic [5:0] v;
        unique case (norm_sel(s))
            3'd2:    v = {2'd0, 2'd2, 2'd1};
            3'd3:    v = {2'd1, 2'd0, 2'd2};
            3'd4:    v = {2'd2, 2'd0, 2'd1};
            3'd5:    v = {2'd1, 2'd2, 2'd0};
            3'd6:    v = {2'd2, 2'd1, 2'd0};
            default: v = {2'd0, 2'd1, 2'd2};
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The phase has seen `limit` ticks once this pulse is counted.
    assign expire = tick && (cnt_q == limit - 1'b1);

endmodule

// File: rtl/rail_seq_delay_sel.sv
module rail_seq_delay_sel
    import rail_seq_pkg::*;
#(
    parameter int TICKS_PER_MS = 10,
    parameter int LEAD_TICKS   = 4,
    parameter int SETTLE_TICKS = 1200,
    parameter int CNT_W        = 16
) (
    input  seq_state_e       state,
    input  logic [2:0]       opt,
    output logic [CNT_W-1:0] limit
);

    logic [CNT_W-1:0] base;

    assign base = CNT_W'(opt_ms(opt)) * CNT_W'(TICKS_PER_MS);

    always_comb begin
        unique case (state)
            ST_UP1, ST_DN1:         limit = base + CNT_W'(LEAD_TICKS);
            ST_HOLD_HI, ST_HOLD_LO: limit = CNT_W'(SETTLE_TICKS);
            default:                limit = base;
        endcase
    end

endmodule

// File: rtl/rail_seq_order_dec.sv
module rail_seq_order_dec
    import rail_seq_pkg::*;
(
    input  logic [2:0]         sel,
    output logic [N_RAILS-1:0] keep_one,
    output logic [N_RAILS-1:0] keep_two
);

    logic [2*N_RAILS-1:0] slots;

    assign slots = drop_slots(sel);

    generate
        for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
            logic [1:0] slot;
            assign slot        = slots[2*r +: 2];
            assign keep_one[r] = (slot >= 2'd1);
            assign keep_two[r] = (slot >= 2'd2);
        end
    endgenerate

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl #(
    parameter int TICKS_PER_MS = 10,
    parameter int LEAD_TICKS   = 4,
    parameter int SETTLE_MS    = 120,
    parameter int CNT_W        = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic [2:0] pd_order_sel,
    input  logic [2:0] dly_opt_sel,
    output logic [2:0] rail_en,
    output logic       busy
);
    import rail_seq_pkg::*;

    localparam int SETTLE_TICKS = SETTLE_MS * TICKS_PER_MS;

    seq_state_e       state_q, state_d;
    logic             en_q;
    logic [2:0]       opt_q, ord_q;
    logic             en_fall, en_rise;
    logic             same_restart, restart, capture, expire;
    logic [CNT_W-1:0] limit;
    logic [2:0]       keep_one, keep_two;

    assign en_fall = en_q && !en;
    assign en_rise = !en_q && en;

    // State register, request history and captured selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            en_q    <= 1'b0;
            opt_q   <= 3'd1;
            ord_q   <= 3'd1;
        end else begin
            state_q <= state_d;
            en_q    <= en;
            if (capture) begin
                opt_q <= dly_opt_sel;
                ord_q <= pd_order_sel;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d      = state_q;
        same_restart = 1'b0;
        unique case (state_q)
            ST_IDLE:    if (en) state_d = ST_UP1;
            ST_UP1: begin
                if (!en)         state_d = ST_IDLE;
                else if (expire) state_d = ST_UP2;
            end
            ST_UP2: begin
                if (en_fall)     same_restart = 1'b1;
                else if (expire) state_d = ST_UP3;
            end
            ST_UP3: begin
                if (en_fall)     same_restart = 1'b1;
                else if (expire) state_d = en ? ST_ON : ST_HOLD_HI;
            end
            ST_ON:      if (!en) state_d = ST_DN1;
            ST_DN1: begin
                if (en)          state_d = ST_ON;
                else if (expire) state_d = ST_DN2;
            end
            ST_DN2: begin
                if (en_rise)     same_restart = 1'b1;
                else if (expire) state_d = ST_DN3;
            end
            ST_DN3: begin
                if (en_rise)     same_restart = 1'b1;
                else if (expire) state_d = en ? ST_HOLD_LO : ST_IDLE;
            end
            ST_HOLD_HI: if (expire) state_d = en ? ST_ON : ST_DN1;
            ST_HOLD_LO: if (expire) state_d = en ? ST_UP1 : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign restart = (state_d != state_q) || same_restart;
    assign capture = (state_d != state_q)
                  && (state_d == ST_UP1 || state_d == ST_DN1);

    // Output decode.
    always_comb begin
        rail_en = 3'b000;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE:                     busy    = 1'b0;
            ST_UP1, ST_HOLD_LO:          rail_en = 3'b000;
            ST_UP2:                      rail_en = 3'b001;
            ST_UP3:                      rail_en = 3'b011;
            ST_ON: begin
                rail_en = 3'b111;
                busy    = 1'b0;
            end
            ST_DN1, ST_HOLD_HI:          rail_en = 3'b111;
            ST_DN2:                      rail_en = keep_one;
            ST_DN3:                      rail_en = keep_two;
            default:                     busy    = 1'b0;
        endcase
    end

    rail_seq_delay_sel #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .LEAD_TICKS   (LEAD_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS),
        .CNT_W        (CNT_W)
    ) delay_i (
        .state (state_q),
        .opt   (opt_q),
        .limit (limit)
    );

    rail_seq_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick),
        .limit   (limit),
        .expire  (expire)
    );

    rail_seq_order_dec order_i (
        .sel      (ord_q),
        .keep_one (keep_one),
        .keep_two (keep_two)
    );

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       en,
    input logic [2:0] rail_en,
    input logic       busy
);

    // R12: never two rails moving in one cycle
    assert_single_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rail_en ^ $past(rail_en)) <= 1);

    // R12: rails hold still across a cycle without a timebase pulse
    assert_frozen_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(rail_en));

    // R10: resting means all low or all high
    assert_rest_levels_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rail_en == 3'b000 || rail_en == 3'b111));

    // R2: rail 2 only rises with rail 1 up
    assert_up_chain_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[1]) |-> rail_en[0]);

    // R2: rail 3 only rises with rail 2 up
    assert_up_chain_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[2]) |-> rail_en[1]);

    // R5: the first rail only rises while the request was high
    assert_first_rise_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[0]) |-> $past(en));

    // R6: the first drop only happens while the request was low
    assert_first_drop_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rail_en) == 3'b111 && rail_en != 3'b111) |-> !$past(en));

endmodule

bind rail_seq_ctrl rail_seq_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .en      (en),
    .rail_en (rail_en),
    .busy    (busy)
);

// File: tb/rail_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rail_seq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       en = 1'b0;
    logic [2:0] pd_order_sel = 3'd1;
    logic [2:0] dly_opt_sel = 3'd1;
    logic [2:0] rail_en;
    logic       busy;

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;
    bit    tick_on = 1'b1;
    int    tick_every = 1;
    int    tick_ctr = 0;

    always #2 clk = ~clk;

    rail_seq_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .en           (en),
        .pd_order_sel (pd_order_sel),
        .dly_opt_sel  (dly_opt_sel),
        .rail_en      (rail_en),
        .busy         (busy)
    );

    // ---------------- behavioural reference model ----------------
    // phases: 0 rest low, 1..3 rising waits, 4 rest high,
    // 5..7 falling waits, 8 settle high, 9 settle low
    int       m_phase = 0;
    int       m_left = 0;
    bit       m_prev_en = 0;
    bit [2:0] m_rail = 3'b000;
    bit       m_busy = 0;
    int       m_opt = 1;
    int       m_ord = 1;
    int       m_drop_q[$];

    function automatic int norm(input int s);
        return (s == 0 || s == 7) ? 1 : s;
    endfunction

    function automatic int ticks_for(input int ph, input int opt);
        int ms_tab[6] = '{10, 30, 60, 120, 2, 16};
        int d = ms_tab[norm(opt) - 1] * 10;
        if (ph == 1 || ph == 5) return d + 4;
        if (ph == 8 || ph == 9) return 1200;
        return d;
    endfunction

    task automatic m_capture();
        m_opt = norm(dly_opt_sel);
        m_ord = norm(pd_order_sel);
        m_drop_q.delete();
        case (m_ord)
            2: m_drop_q = '{2, 0, 1};
            3: m_drop_q = '{1, 2, 0};
            4: m_drop_q = '{1, 0, 2};
            5: m_drop_q = '{0, 2, 1};
            6: m_drop_q = '{0, 1, 2};
            default: m_drop_q = '{2, 1, 0};
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_prev_en = 0;
            m_rail = 3'b000; m_busy = 0; m_opt = 1; m_ord = 1;
        end else begin
            bit done, fell, rose, again;
            int nxt;
            done = tick && (m_left == 1);
            fell = m_prev_en && !en;
            rose = !m_prev_en && en;
            again = 0;
            nxt = m_phase;
            if (tick && !done) m_left--;
            case (m_phase)
                0: if (en) begin nxt = 1; m_capture(); end
                1: if (!en) nxt = 0;
                   else if (done) begin m_rail[0] = 1; nxt = 2; end
                2: if (fell) again = 1;
                   else if (done) begin m_rail[1] = 1; nxt = 3; end
                3: if (fell) again = 1;
                   else if (done) begin m_rail[2] = 1; nxt = en ? 4 : 8; end
                4: if (!en) begin nxt = 5; m_capture(); end
                5: if (en) nxt = 4;
                   else if (done) begin m_rail[m_drop_q.pop_front()] = 0; nxt = 6; end
                6: if (rose) again = 1;
                   else if (done) begin m_rail[m_drop_q.pop_front()] = 0; nxt = 7; end
                7: if (rose) again = 1;
                   else if (done) begin m_rail[m_drop_q.pop_front()] = 0; nxt = en ? 9 : 0; end
                8: if (done) begin
                       nxt = en ? 4 : 5;
                       if (!en) m_capture();
                   end
                9: if (done) begin
                       nxt = en ? 1 : 0;
                       if (en) m_capture();
                   end
                default: nxt = 0;
            endcase
            if (nxt != m_phase || again) m_left = ticks_for(nxt, m_opt);
            m_phase = nxt;
            m_busy = !(m_phase == 0 || m_phase == 4);
            m_prev_en = en;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (cmp_on) begin
            tests++;
            if (rail_en !== m_rail || busy !== m_busy) begin
                fails++;
                $display("FAIL %s model compare: rail_en=%b busy=%b expected rail_en=%b busy=%b",
                         cur_req, rail_en, busy, m_rail, m_busy);
            end
        end
    end

    // ---------------- timebase ----------------
    always @(negedge clk) begin
        tick_ctr++;
        tick = tick_on && ((tick_ctr % tick_every) == 0);
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_until_bit(input int idx, input bit val, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (rail_en[idx] !== val && n < 20000);
    endtask

    task automatic wait_pattern(input logic [2:0] pat);
        int n = 0;
        while (rail_en !== pat && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_rest();
        int n = 0;
        do begin @(negedge clk); n++; end while (busy !== 1'b0 && n < 20000);
    endtask

    task automatic wait_change_from_all_on();
        int n = 0;
        while (rail_en === 3'b111 && n < 20000) begin @(negedge clk); n++; end
    endtask

    function automatic int keep_after(input int sel, input int step);
        int s = norm(sel);
        if (step == 1) begin
            case (s) 3, 4: return 5; 5, 6: return 6; default: return 3; endcase
        end
        case (s) 2, 5: return 2; 4, 6: return 4; default: return 1; endcase
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int n;
        cyc(4);
        cur_req = "R1";
        check("R1 reset rail_en", rail_en, 0);
        check("R1 reset busy", busy, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        cyc(30);
        check("R1 idle rail_en", rail_en, 0);

        // R2 / R4: nominal power-up, option 1
        cur_req = "R2";
        en = 1'b1;
        count_until_bit(0, 1'b1, n); check("R2 first release", n, 105);
        count_until_bit(1, 1'b1, n); check("R2 second release", n, 100);
        count_until_bit(2, 1'b1, n); check("R2 third release", n, 100);
        cyc(1);
        check("R10 busy at rest high", busy, 0);

        // R3: nominal power-down, order 1
        cur_req = "R3";
        en = 1'b0;
        count_until_bit(2, 1'b0, n); check("R3 first drop time", n, 105);
        check("R3 first drop pattern", rail_en, 3);
        count_until_bit(1, 1'b0, n); check("R3 second drop time", n, 100);
        wait_rest();
        check("R3 final low", rail_en, 0);

        // R3: every order code, short delays
        dly_opt_sel = 3'd5;
        for (int s = 0; s < 8; s++) begin
            pd_order_sel = 3'(s);
            en = 1'b1; wait_rest();
            en = 1'b0; wait_change_from_all_on();
            check($sformatf("R3 order %0d step1", s), rail_en, keep_after(s, 1));
            wait_pattern(3'(keep_after(s, 2)));
            check($sformatf("R3 order %0d step2", s), rail_en, keep_after(s, 2));
            wait_rest();
        end

        // R4: every delay option code
        cur_req = "R4";
        pd_order_sel = 3'd1;
        for (int o = 0; o < 8; o++) begin
            int ms_tab[6] = '{10, 30, 60, 120, 2, 16};
            dly_opt_sel = 3'(o);
            en = 1'b1;
            count_until_bit(0, 1'b1, n);
            check($sformatf("R4 option %0d lead", o), n, ms_tab[norm(o) - 1] * 10 + 5);
            wait_rest();
            en = 1'b0; wait_rest();
        end

        // R5: request glitch during the first rising timer
        cur_req = "R5";
        dly_opt_sel = 3'd1;
        en = 1'b1; cyc(50); en = 1'b0; cyc(2);
        check("R5 abort rail_en", rail_en, 0);
        check("R5 abort busy", busy, 0);

        // R6: request glitch during the first falling timer
        cur_req = "R6";
        en = 1'b1; wait_rest();
        en = 1'b0; cyc(50); en = 1'b1; cyc(2);
        check("R6 abort rail_en", rail_en, 7);
        check("R6 abort busy", busy, 0);

        // R7: interrupted power-up
        cur_req = "R7";
        en = 1'b0; wait_rest();
        en = 1'b1; count_until_bit(0, 1'b1, n);
        cyc(30); en = 1'b0;
        count_until_bit(1, 1'b1, n); check("R7 restarted timer", n, 101);
        wait_pattern(3'b111);
        check("R7 settle busy", busy, 1);
        n = 0;
        while (rail_en === 3'b111 && n < 20000) begin @(negedge clk); n++; end
        check("R7 settle then drop", n, 1304);
        wait_rest();
        check("R7 final low", rail_en, 0);

        // R8: interrupted power-down
        cur_req = "R8";
        en = 1'b1; wait_rest();
        en = 1'b0; wait_change_from_all_on();
        cyc(30); en = 1'b1;
        count_until_bit(1, 1'b0, n); check("R8 restarted timer", n, 101);
        wait_pattern(3'b000);
        check("R8 settle busy", busy, 1);
        count_until_bit(0, 1'b1, n); check("R8 settle then rise", n, 1304);
        wait_rest();
        check("R8 final high", rail_en, 7);

        // R9: request reverts during the settle holds
        cur_req = "R9";
        en = 1'b0; wait_rest();
        en = 1'b1; count_until_bit(0, 1'b1, n);
        en = 1'b0; wait_pattern(3'b111);
        cyc(100); en = 1'b1;
        wait_rest();
        check("R9 stays high", rail_en, 7);
        en = 1'b0; wait_change_from_all_on();
        en = 1'b1; wait_pattern(3'b000);
        cyc(100); en = 1'b0;
        wait_rest();
        check("R9 stays low", rail_en, 0);

        // R11: selects changed mid-sequence
        cur_req = "R11";
        en = 1'b1; cyc(10);
        dly_opt_sel = 3'd5;
        count_until_bit(0, 1'b1, n); check("R11 delay held", n, 95);
        wait_rest();
        pd_order_sel = 3'd2; en = 1'b0; cyc(5);
        pd_order_sel = 3'd5;
        wait_change_from_all_on();
        check("R11 order held", rail_en, 3);
        wait_rest();

        // R12: sparse and absent timebase
        cur_req = "R12";
        tick_every = 3;
        en = 1'b1; wait_rest();
        en = 1'b0; wait_rest();
        tick_on = 1'b0;
        en = 1'b1; cyc(500);
        check("R12 no tick rail_en", rail_en, 0);
        check("R12 no tick busy", busy, 1);
        tick_on = 1'b1; tick_every = 1;
        wait_rest();
        check("R12 resumes", rail_en, 7);

        cmp_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule